// File: doc/BRIEF.md
# Debug Port Mode Selector

This block decides whether a shared two-wire debug port is run as a JTAG port or as a serial-wire port. On every rising edge of the shared debug clock it samples the shared mode/data line. It looks for an in-band switching pattern made of three parts: a run of more than 50 ones, a 16-bit magic word sent most significant bit first, and a second run of more than 50 ones. After reset the port is in JTAG mode. The word 0x79E7 moves the port to serial-wire mode, and the word 0x3CE7 moves it back to JTAG.

The selected mode also steers the shared data-out pin. In serial-wire mode the pin carries asynchronous trace data. In JTAG mode it carries the test data output. A pin-level strap decides whether mode selection is allowed at all. The block captures the strap on the first clock after reset, so a later change of the strap has no effect until the next reset.

The control core is a three-state machine:
- ST_HUNT counts consecutive ones. A 0 that arrives after at least 51 ones takes the transition *hunt→word* and becomes bit 15 of the word.
- ST_WORD shifts in the other 15 bits. On the 16th bit it takes *word→tail* when the word is the switch word for the current mode, and *word→hunt* otherwise.
- ST_TAIL counts the trailing ones. On the 51st consecutive one it takes *tail→hunt*, and the mode toggles on that same edge. A 0 seen in ST_TAIL takes *abort→hunt* and the mode is unchanged.
- While selection is disabled, every state goes back to ST_HUNT.

Top module: `dbg_port_sel`

## Requirements
- R1: After reset, mode_sw_o and trace_en_o are 0 (JTAG mode) and pin_o equals tdo_i.
- R2: In JTAG mode, the following sequence sets mode_sw_o to 1: at least 51 ones, then the bits of 0x79E7 sent MSB first, then at least 51 ones. The output changes on the clock edge that samples the 51st trailing one, and not one edge earlier.
- R3: In serial-wire mode, the same framing with the word 0x3CE7 returns mode_sw_o to 0.
- R4: pin_o equals trace_i and trace_en_o is 1 when mode_sw_o is 1. pin_o equals tdo_i and trace_en_o is 0 when mode_sw_o is 0.
- R5: A leading run of only 50 ones before the word does not arm word capture, and the mode stays unchanged.
- R6: A 0 at any point in the trailing run aborts the switch. This includes a 0 right after exactly 50 trailing ones. The mode stays unchanged.
- R7: A word that is not the current mode's switch word leaves the mode unchanged. This covers 0x79E7 sent in serial-wire mode, 0x3CE7 sent in JTAG mode, and any other value.
- R8: A strap that is high (1) on the first clock after reset disables selection until the next reset, and the mode stays JTAG. A strap that is low at that point keeps selection enabled even if the strap later rises.
- R9: The run counter saturates, so a leading run of any length (for example 200 ones) still arms capture. A completed trailing run also counts as the leading run of a word that follows it directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared debug clock; the line is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Shared mode/data line |
| strap_i | input | 1 | Selection strap; 0 enables mode selection; captured after reset |
| tdo_i | input | 1 | Test data output from the JTAG engine |
| trace_i | input | 1 | Asynchronous trace data from the trace encoder |
| mode_sw_o | output | 1 | 1 = serial-wire mode, 0 = JTAG mode |
| trace_en_o | output | 1 | Trace drive enable for the shared pin |
| pin_o | output | 1 | Muxed shared data-out pin |

## Verification
The assertions take three things for granted. The line is stable around each rising clock edge. The strap does not change across the first clock after reset is released. No X is driven on the line after reset. The bench meets these conditions in the following way. It changes the line and the strap only on falling edges. It holds the strap fixed from before reset until well after the capture edge. It puts a run of twenty zeros between table vectors, which returns the machine to ST_HUNT with an empty run count, so each vector starts from a known state.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_WORD = 2'd1,
        ST_TAIL = 2'd2
    } dps_state_e;

    localparam logic MODE_JTAG = 1'b0;
    localparam logic MODE_SW   = 1'b1;

endpackage

// File: rtl/dps_run_cnt.sv
module dps_run_cnt #(
    parameter int RUN_MIN = 51
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic one_i,
    output logic sat_o,
    output logic last_o
);
    localparam int CW = $clog2(RUN_MIN + 1);
    localparam logic [CW-1:0] CMAX  = CW'(RUN_MIN);
    localparam logic [CW-1:0] CLAST = CW'(RUN_MIN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!one_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CMAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sat_o  = (cnt_q == CMAX);
    assign last_o = (cnt_q == CLAST);

    // R9: saturation holds while ones continue
    p_run_sat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == CMAX && one_i) |=> (cnt_q == CMAX));

    // R9: counter never passes its ceiling
    p_run_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CMAX);

endmodule

// File: rtl/dps_word_shift.sv
module dps_word_shift #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o,
    output logic         last_o
);
    localparam int BW = $clog2(W + 1);
    localparam logic [BW-1:0] BLAST = BW'(W - 1);

    logic [W-2:0]  sh_q;
    logic [BW-1:0] bits_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q   <= '0;
            bits_q <= '0;
        end else if (start_i) begin
            sh_q   <= {{(W-2){1'b0}}, bit_i};
            bits_q <= BW'(1);
        end else if (shift_i) begin
            sh_q   <= {sh_q[W-3:0], bit_i};
            bits_q <= (bits_q == BLAST) ? '0 : bits_q + 1'b1;
        end
    end

    assign word_o = {sh_q, bit_i};
    assign last_o = (bits_q == BLAST);

    // R2: bit count stays within one word
    p_bits_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bits_q < BW'(W));

endmodule

// File: rtl/dps_sel_fsm.sv
module dps_sel_fsm
    import dps_pkg::*;
#(
    parameter int         W       = 16,
    parameter logic [W-1:0] TO_SW   = 16'h79E7,
    parameter logic [W-1:0] TO_JTAG = 16'h3CE7
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,
    input  logic         line_i,
    input  logic         run_sat_i,
    input  logic         run_last_i,
    input  logic [W-1:0] word_i,
    input  logic         word_last_i,
    output logic         mode_o,
    output logic         start_o,
    output logic         shift_o,
    output logic         run_one_o
);
    dps_state_e   state_q, state_n;
    logic         mode_q, mode_n;
    logic [W-1:0] target;

    assign target = (mode_q == MODE_SW) ? TO_JTAG : TO_SW;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_HUNT;
            mode_q  <= MODE_JTAG;
        end else begin
            state_q <= state_n;
            mode_q  <= mode_n;
        end
    end

    always_comb begin
        state_n = state_q;
        mode_n  = mode_q;
        if (!en_i) begin
            state_n = ST_HUNT;
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    if (!line_i && run_sat_i) state_n = ST_WORD;
                end
                ST_WORD: begin
                    if (word_last_i) begin
                        state_n = (word_i == target) ? ST_TAIL : ST_HUNT;
                    end
                end
                ST_TAIL: begin
                    if (!line_i) begin
                        state_n = ST_HUNT;
                    end else if (run_last_i) begin
                        state_n = ST_HUNT;
                        mode_n  = ~mode_q;
                    end
                end
                default: state_n = ST_HUNT;
            endcase
        end
    end

    always_comb begin
        start_o   = 1'b0;
        shift_o   = 1'b0;
        run_one_o = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                start_o   = en_i && !line_i && run_sat_i;
                run_one_o = en_i && line_i;
            end
            ST_WORD: begin
                shift_o   = en_i;
            end
            ST_TAIL: begin
                run_one_o = en_i && line_i;
            end
            default: ;
        endcase
    end

    assign mode_o = mode_q;

    // R6: mode only moves on a completed trailing run
    p_mode_tail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(mode_q) |-> $past(state_q == ST_TAIL && line_i && run_last_i));

    // R5: word capture only after a saturated leading run
    p_word_after_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_WORD && $past(state_q) == ST_HUNT) |-> $past(run_sat_i));

    // R7: trailing run only after the matching word
    p_tail_needs_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_TAIL && $past(state_q) == ST_WORD) |-> $past(word_i == target));

endmodule

// File: rtl/dps_pin_mux.sv
module dps_pin_mux (
    input  logic sel_sw_i,
    input  logic tdo_i,
    input  logic trace_i,
    output logic trace_en_o,
    output logic pin_o
);
    always_comb begin
        trace_en_o = sel_sw_i;
        pin_o      = sel_sw_i ? trace_i : tdo_i;
    end
endmodule

// File: rtl/dbg_port_sel.sv
module dbg_port_sel #(
    parameter int RUN_MIN = 51,
    parameter int WORD_W  = 16,
    parameter logic [WORD_W-1:0] TO_SW   = 16'h79E7,
    parameter logic [WORD_W-1:0] TO_JTAG = 16'h3CE7
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    input  logic strap_i,
    input  logic tdo_i,
    input  logic trace_i,
    output logic mode_sw_o,
    output logic trace_en_o,
    output logic pin_o
);
    logic              cap_q, strap_q, sel_en;
    logic              run_one, run_sat, run_last;
    logic              start, shift, word_last;
    logic [WORD_W-1:0] word;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cap_q   <= 1'b0;
            strap_q <= 1'b0;
        end else if (!cap_q) begin
            cap_q   <= 1'b1;
            strap_q <= strap_i;
        end
    end

    assign sel_en = cap_q ? !strap_q : !strap_i;

    dps_run_cnt #(.RUN_MIN(RUN_MIN)) u_run (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .one_i  (run_one),
        .sat_o  (run_sat),
        .last_o (run_last)
    );

    dps_word_shift #(.W(WORD_W)) u_shift (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start),
        .shift_i (shift),
        .bit_i   (line_i),
        .word_o  (word),
        .last_o  (word_last)
    );

    dps_sel_fsm #(.W(WORD_W), .TO_SW(TO_SW), .TO_JTAG(TO_JTAG)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (sel_en),
        .line_i      (line_i),
        .run_sat_i   (run_sat),
        .run_last_i  (run_last),
        .word_i      (word),
        .word_last_i (word_last),
        .mode_o      (mode_sw_o),
        .start_o     (start),
        .shift_o     (shift),
        .run_one_o   (run_one)
    );

    dps_pin_mux u_mux (
        .sel_sw_i   (mode_sw_o),
        .tdo_i      (tdo_i),
        .trace_i    (trace_i),
        .trace_en_o (trace_en_o),
        .pin_o      (pin_o)
    );

    // R4: JTAG mode never drives trace onto the pin
    p_jtag_pin_tdo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_sw_o |-> (pin_o == tdo_i && !trace_en_o));

    // R8: disabled selection keeps JTAG mode
    p_strap_locks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_en |-> !mode_sw_o);

    // R8: captured strap is frozen until reset
    p_strap_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_q |=> $stable(strap_q));

endmodule

// File: tb/dbg_port_sel_test.sv
module dbg_port_sel_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line = 1'b0;
    logic strap = 1'b0;
    logic tdo = 1'b0;
    logic trace = 1'b1;
    logic mode_sw, trace_en, pin;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dbg_port_sel uut (
        .clk_i(clk), .rst_ni(rst_n), .line_i(line), .strap_i(strap),
        .tdo_i(tdo), .trace_i(trace), .mode_sw_o(mode_sw),
        .trace_en_o(trace_en), .pin_o(pin)
    );

    localparam int NV = 10;
    localparam int          LEAD [NV] = '{60, 60, 60, 60, 50, 51, 60, 200, 60, 60};
    localparam logic [15:0] WRD  [NV] = '{16'h79E7, 16'h79E7, 16'h3CE7, 16'h3CE7, 16'h79E7,
                                          16'h79E7, 16'h3CE7, 16'h3CE7, 16'h79E8, 16'h79E7};
    localparam int          TAIL [NV] = '{60, 60, 60, 60, 60, 51, 50, 80, 60, 60};
    localparam logic        EXP  [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
                                          1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        line = b;
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic separate();
        for (int i = 0; i < 20; i++) send_bit(1'b0);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        strap = s;
        line  = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_pin(input string req);
        tdo = 1'b0; trace = 1'b1;
        #0.5;
        chk({req, " pin"}, {7'd0, pin}, {7'd0, mode_sw ? trace : tdo});
        tdo = 1'b1; trace = 1'b0;
        #0.5;
        chk({req, " pin"}, {7'd0, pin}, {7'd0, mode_sw ? trace : tdo});
        chk({req, " trace_en"}, {7'd0, trace_en}, {7'd0, mode_sw});
    endtask

    initial begin
        #700000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        // R1: reset state
        chk("R1 mode", {7'd0, mode_sw}, 8'd0);
        check_pin("R1");

        // table walk (R2 R3 R4 R5 R6 R7 R9)
        for (int v = 0; v < NV; v++) begin
            send_ones(LEAD[v]);
            send_word(WRD[v]);
            send_ones(TAIL[v]);
            separate();
            chk($sformatf("R2/R3/R5/R6/R7/R9 vec%0d mode", v), {7'd0, mode_sw}, {7'd0, EXP[v]});
            check_pin($sformatf("R4 vec%0d", v));
        end

        // R2: exact edge of the switch (mode is 1 from table end)
        send_ones(60); send_word(16'h3CE7); send_ones(60); separate();
        chk("R3 back to jtag", {7'd0, mode_sw}, 8'd0);
        send_ones(60); send_word(16'h79E7); send_ones(50);
        @(negedge clk);
        chk("R2 not after 50 tail ones", {7'd0, mode_sw}, 8'd0);
        line = 1'b1;
        @(negedge clk);
        chk("R2 set after 51st tail one", {7'd0, mode_sw}, 8'd1);
        line = 1'b1;

        // R9: chained word directly after a completed tail
        send_ones(5); send_word(16'h3CE7); send_ones(51);
        @(negedge clk);
        chk("R9 chained switch", {7'd0, mode_sw}, 8'd0);
        separate();

        // R6: zero in the middle of the tail
        send_ones(60); send_word(16'h79E7); send_ones(30); send_bit(1'b0); send_ones(60);
        separate();
        chk("R6 mid-tail abort", {7'd0, mode_sw}, 8'd0);

        // R8: strap high at reset disables selection
        do_reset(1'b1);
        send_ones(60); send_word(16'h79E7); send_ones(60); separate();
        chk("R8 strap high blocks", {7'd0, mode_sw}, 8'd0);
        check_pin("R8");
        strap = 1'b0;
        send_ones(60); send_word(16'h79E7); send_ones(60); separate();
        chk("R8 strap drop ignored before reset", {7'd0, mode_sw}, 8'd0);

        // R8: strap low at reset, later rise ignored
        do_reset(1'b0);
        strap = 1'b1;
        send_ones(60); send_word(16'h79E7); send_ones(60); separate();
        chk("R8 strap rise ignored", {7'd0, mode_sw}, 8'd1);
        check_pin("R4 after R8");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule